// File: doc/BRIEF.md
# ATM Cell Delineation Engine

This block finds ATM cell boundaries in a byte-aligned receive stream that arrives one byte per clock, qualified by a valid strobe. It has no framing pulse to work from. It uses the header error control (HEC) byte that closes every five-byte cell header. A three-state machine moves through the following states:

- **Searching:** the check runs on a sliding window, one byte at a time.
- **Tentative:** the block locks onto a candidate boundary and verifies one header per 53-byte cell.
- **Locked:** the block tolerates, and where possible corrects, isolated header errors.

The block reports its state on a loss-of-cell-delineation (LCD) defect flag and a 2-bit delineation code. Four sticky interrupt bits record four kinds of event:

- declaration of the defect
- clearance of the defect
- correctable header errors
- uncorrectable header errors

The host clears these bits by writing ones to them. An active-low interrupt line combines the bits with a per-bit enable mask. A one-cycle marker flags every header accepted while locked, so downstream logic can align to cells.

The entry threshold (consecutive good headers) and the exit threshold (consecutive errored headers) are run-time inputs. A zero on either input selects a built-in default.

Top module: `atm_cell_delin`

## Requirements
- R1: After synchronous reset the block searches: delineation code 2'b10, lcd_defect 1, all four interrupt status bits 0, irq_n 1, cell_mark 0.
- R2: A header is valid when its fifth byte equals a CRC-8 with the following definition, XORed with 8'h55:
  - generator x^8+x^2+x+1
  - initial value zero
  - input is the first four bytes, earliest byte first and most significant bit first
- R3: While searching, every accepted byte that completes a five-byte window is checked. The first valid window gives code 2'b01 at that byte's clock edge. The block then checks the header whose fifth byte is exactly 53 accepted bytes later, and every 53 bytes after that.
- R4: In the tentative state, one invalid header returns the block to searching (code 2'b10, lcd_defect 1) without raising status bit 0.
- R5: After entry to the tentative state, delta_thr further consecutive valid headers (6 when delta_thr is 0) move the block to locked. At that edge the code becomes 2'b00, lcd_defect becomes 0 and status bit 1 is set.
- R6: While locked, a header with exactly one flipped bit among its 40 bits sets status bit 3 when the previous header was error-free. The block stays locked, and the header counts as an errored cell.
- R7: While locked, any other header error sets status bit 2. This covers multi-bit errors, and single-bit errors that follow an errored header.
- R8: alpha_thr consecutive errored headers while locked (7 when alpha_thr is 0) return the block to searching. At that edge the code becomes 2'b10, lcd_defect becomes 1 and status bit 0 is set.
- R9: An error-free header while locked clears the consecutive-error count and re-enables single-bit correction.
- R10: Status bits are sticky. When clr_wr is high, each bit whose clr_bits position is 1 is cleared, and positions holding 0 leave their bits unchanged. A new event in the same cycle wins over the clear.
- R11: irq_n is low exactly when some status bit and the same irq_mask bit are both 1. It is updated at the same edge as the status bits.
- R12: A byte presented with in_vld low is ignored. It is not shifted into the window, not counted toward the 53-byte spacing, and changes no state.
- R13: cell_mark is high for one cycle after each accepted header (valid or corrected) that leaves the block locked, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Qualifies in_byte |
| in_byte | input | 8 | Received stream byte |
| delta_thr | input | 4 | Valid headers needed to lock (0 selects 6) |
| alpha_thr | input | 4 | Errored headers needed to lose lock (0 selects 7) |
| irq_mask | input | 4 | Per-bit interrupt enable |
| clr_wr | input | 1 | Write strobe for clearing status bits |
| clr_bits | input | 4 | Ones clear the matching status bits |
| lcd_defect | output | 1 | Loss-of-cell-delineation defect flag |
| dlin_code | output | 2 | 00 locked, 01 tentative, 10 searching |
| irq_stat | output | 4 | Sticky status bits: bit0 defect declared, bit1 defect cleared, bit2 uncorrectable HEC, bit3 corrected HEC |
| irq_n | output | 1 | Active-low interrupt request |
| cell_mark | output | 1 | One-cycle pulse per accepted locked header |

## Verification
Each pattern exercises a different behaviour:

- **Clean cells** show that locking waits for the exact threshold count.
- **Single-bit header flips:** when the previous header was clean, the flip must be classed as corrected. When the previous header was errored, it must be classed as uncorrectable.
- **Two-bit flips** must never be classed as corrected.
- **A clean header between two errored runs** shows whether the error count restarts.

Further patterns cover the search logic and stream handling:

- A window whose check byte lacks the 8'h55 offset must not be taken as a header.
- Junk bytes placed before the first header show that the search slides byte by byte and aligns to that header.
- A run interleaved with idle cycles that carry garbage data shows that unqualified bytes are ignored.

The default thresholds of 6 and 7 are checked by exact cell counts in both directions.

// File: rtl/atm_delin_pkg.sv
package atm_delin_pkg;

  typedef enum logic [1:0] {
    ST_SYNC = 2'b00,
    ST_PRE  = 2'b01,
    ST_HUNT = 2'b10
  } dl_state_e;

  localparam logic [7:0] HEC_POLY  = 8'h07;
  localparam logic [7:0] HEC_COSET = 8'h55;

  localparam int IRQ_W      = 4;
  localparam int IRQ_LCDSET = 0;
  localparam int IRQ_LCDCLR = 1;
  localparam int IRQ_UNCORR = 2;
  localparam int IRQ_CORR   = 3;

  // One byte of CRC-8 update, MSB first.
  function automatic logic [7:0] crc8_step(logic [7:0] crc, logic [7:0] d);
    logic [7:0] c;
    c = crc ^ d;
    for (int k = 0; k < 8; k++)
      c = c[7] ? ({c[6:0], 1'b0} ^ HEC_POLY) : {c[6:0], 1'b0};
    return c;
  endfunction

  // Syndrome caused by flipping bit b of a header of nb data bytes plus HEC.
  // Bits 0..7 sit in the HEC byte, bit 8 upward walk back from the newest data byte.
  function automatic logic [7:0] unit_syndrome(int b, int nb);
    logic [7:0] c;
    int t;
    if (b < 8) return 8'(1 << b);
    t = b - 8;
    c = 8'h00;
    for (int i = nb - 1; i >= 0; i--)
      c = crc8_step(c, (i == t / 8) ? 8'(1 << (t % 8)) : 8'h00);
    return c;
  endfunction

endpackage

// File: rtl/hdr_window.sv
module hdr_window #(
  parameter int HDR_LEN = 5,
  parameter int BYTE_W  = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              vld,
  input  logic [BYTE_W-1:0]                 din,
  output logic [HDR_LEN-2:0][BYTE_W-1:0]    hdr_bytes,
  output logic                              win_full
);
  localparam int NPREV = HDR_LEN - 1;
  localparam int FW    = $clog2(HDR_LEN);

  logic [NPREV-1:0][BYTE_W-1:0] win_q;
  logic [FW-1:0]                fill_q;

  // Index 0 holds the newest previous byte.
  for (genvar g = 0; g < NPREV; g++) begin : g_tap
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst)      win_q[g] <= '0;
        else if (vld) win_q[g] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst)      win_q[g] <= '0;
        else if (vld) win_q[g] <= win_q[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                  fill_q <= '0;
    else if (vld && fill_q != FW'(NPREV))     fill_q <= fill_q + 1'b1;
  end

  assign hdr_bytes = win_q;
  assign win_full  = (fill_q == FW'(NPREV));

  AST_FILL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !vld |=> $stable(fill_q)); // R12
endmodule

// File: rtl/hec_check.sv
module hec_check
  import atm_delin_pkg::*;
#(
  parameter int HDR_LEN = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [HDR_LEN-2:0][7:0]    hdr_bytes,
  input  logic [7:0]                 hec_in,
  output logic                       hdr_clean,
  output logic                       hdr_single
);
  localparam int NBITS = HDR_LEN * 8;

  logic [7:0]       crc;
  logic [7:0]       syn;
  logic [NBITS-1:0] hit;

  always_comb begin
    crc = 8'h00;
    for (int i = HDR_LEN - 2; i >= 0; i--)
      crc = crc8_step(crc, hdr_bytes[i]);
  end

  assign syn       = crc ^ HEC_COSET ^ hec_in;
  assign hdr_clean = (syn == 8'h00);

  // Parallel match of the syndrome against every single-bit error pattern.
  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    assign hit[b] = (syn == unit_syndrome(b, HDR_LEN - 1));
  end

  assign hdr_single = |hit;

  AST_ONE_SYNDROME: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit)); // R6
  AST_CLEAN_NOT_SINGLE: assert property (@(posedge clk) disable iff (rst)
    !(hdr_clean && hdr_single)); // R7
endmodule

// File: rtl/delin_fsm.sv
module delin_fsm
  import atm_delin_pkg::*;
#(
  parameter int CELL_LEN  = 53,
  parameter int CNT_W     = 4,
  parameter int DELTA_DEF = 6,
  parameter int ALPHA_DEF = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             vld,
  input  logic             win_full,
  input  logic             hdr_clean,
  input  logic             hdr_single,
  input  logic [CNT_W-1:0] delta_thr,
  input  logic [CNT_W-1:0] alpha_thr,
  output dl_state_e        state_q,
  output logic             lcd_q,
  output logic             mark_q,
  output logic [IRQ_W-1:0] events
);
  localparam int PW = $clog2(CELL_LEN);
  localparam logic [PW-1:0] LAST = PW'(CELL_LEN - 1);

  dl_state_e        st_n;
  logic [PW-1:0]    pos_q, pos_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             corr_q, corr_n;
  logic             mark_n;
  logic             slot;
  logic [CNT_W:0]   cnt_inc, delta_eff, alpha_eff;

  assign slot      = vld && (pos_q == LAST);
  assign cnt_inc   = {1'b0, cnt_q} + 1'b1;
  assign delta_eff = (delta_thr == '0) ? (CNT_W+1)'(DELTA_DEF) : {1'b0, delta_thr};
  assign alpha_eff = (alpha_thr == '0) ? (CNT_W+1)'(ALPHA_DEF) : {1'b0, alpha_thr};

  always_comb begin
    st_n   = state_q;
    pos_n  = pos_q;
    cnt_n  = cnt_q;
    corr_n = corr_q;
    mark_n = 1'b0;
    events = '0;
    if (vld) begin
      pos_n = (pos_q == LAST) ? '0 : pos_q + 1'b1;
      unique case (state_q)
        ST_HUNT: begin
          if (win_full && hdr_clean) begin
            st_n  = ST_PRE;
            pos_n = '0;
            cnt_n = '0;
          end
        end
        ST_PRE: begin
          if (slot) begin
            if (!hdr_clean) begin
              st_n  = ST_HUNT;
              cnt_n = '0;
            end else if (cnt_inc >= delta_eff) begin
              st_n   = ST_SYNC;
              cnt_n  = '0;
              corr_n = 1'b1;
              mark_n = 1'b1;
              events[IRQ_LCDCLR] = 1'b1;
            end else begin
              cnt_n = cnt_inc[CNT_W-1:0];
            end
          end
        end
        default: begin
          if (slot) begin
            if (hdr_clean) begin
              cnt_n  = '0;
              corr_n = 1'b1;
              mark_n = 1'b1;
            end else begin
              corr_n = 1'b0;
              if (corr_q && hdr_single) begin
                events[IRQ_CORR] = 1'b1;
                mark_n = 1'b1;
              end else begin
                events[IRQ_UNCORR] = 1'b1;
              end
              if (cnt_inc >= alpha_eff) begin
                st_n   = ST_HUNT;
                cnt_n  = '0;
                mark_n = 1'b0;
                events[IRQ_LCDSET] = 1'b1;
              end else begin
                cnt_n = cnt_inc[CNT_W-1:0];
              end
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HUNT;
      pos_q   <= '0;
      cnt_q   <= '0;
      corr_q  <= 1'b0;
      mark_q  <= 1'b0;
      lcd_q   <= 1'b1;
    end else begin
      state_q <= st_n;
      pos_q   <= pos_n;
      cnt_q   <= cnt_n;
      corr_q  <= corr_n;
      mark_q  <= mark_n;
      lcd_q   <= (st_n != ST_SYNC);
    end
  end

  AST_PRE_FROM_HUNT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PRE && $past(state_q) != ST_PRE) |-> $past(state_q) == ST_HUNT); // R3
  AST_SYNC_FROM_PRE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SYNC && $past(state_q) != ST_SYNC) |-> $past(state_q) == ST_PRE); // R5
  AST_IDLE_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
    !vld |=> $stable(state_q)); // R12
  AST_MARK_LOCKED: assert property (@(posedge clk) disable iff (rst)
    mark_q |-> state_q == ST_SYNC); // R13
endmodule

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_vec,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_vec,
  input  logic [N-1:0] mask,
  output logic [N-1:0] stat_q,
  output logic         irq_n_q
);
  logic [N-1:0] stat_n;

  assign stat_n = (stat_q & ~(clr_wr ? clr_vec : '0)) | set_vec;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= '0;
      irq_n_q <= 1'b1;
    end else begin
      stat_q  <= stat_n;
      irq_n_q <= ~|(stat_n & mask);
    end
  end

  AST_W1C: assert property (@(posedge clk) disable iff (rst)
    clr_wr |=> ((stat_q & $past(clr_vec & ~set_vec)) == '0)); // R10
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    !clr_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R10
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    $stable(mask) |-> (irq_n_q == ~|(stat_q & mask))); // R11
endmodule

// File: rtl/atm_cell_delin.sv
module atm_cell_delin
  import atm_delin_pkg::*;
#(
  parameter int HDR_LEN   = 5,
  parameter int CELL_LEN  = 53,
  parameter int CNT_W     = 4,
  parameter int DELTA_DEF = 6,
  parameter int ALPHA_DEF = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [7:0]       in_byte,
  input  logic [CNT_W-1:0] delta_thr,
  input  logic [CNT_W-1:0] alpha_thr,
  input  logic [3:0]       irq_mask,
  input  logic             clr_wr,
  input  logic [3:0]       clr_bits,
  output logic             lcd_defect,
  output logic [1:0]       dlin_code,
  output logic [3:0]       irq_stat,
  output logic             irq_n,
  output logic             cell_mark
);
  logic [HDR_LEN-2:0][7:0] hdr_bytes;
  logic                    win_full;
  logic                    hdr_clean;
  logic                    hdr_single;
  dl_state_e               state;
  logic [IRQ_W-1:0]        events;

  hdr_window #(.HDR_LEN(HDR_LEN), .BYTE_W(8)) u_win (
    .clk(clk), .rst(rst), .vld(in_vld), .din(in_byte),
    .hdr_bytes(hdr_bytes), .win_full(win_full)
  );

  hec_check #(.HDR_LEN(HDR_LEN)) u_hec (
    .clk(clk), .rst(rst), .hdr_bytes(hdr_bytes), .hec_in(in_byte),
    .hdr_clean(hdr_clean), .hdr_single(hdr_single)
  );

  delin_fsm #(
    .CELL_LEN(CELL_LEN), .CNT_W(CNT_W),
    .DELTA_DEF(DELTA_DEF), .ALPHA_DEF(ALPHA_DEF)
  ) u_fsm (
    .clk(clk), .rst(rst), .vld(in_vld), .win_full(win_full),
    .hdr_clean(hdr_clean), .hdr_single(hdr_single),
    .delta_thr(delta_thr), .alpha_thr(alpha_thr),
    .state_q(state), .lcd_q(lcd_defect), .mark_q(cell_mark), .events(events)
  );

  irq_regs #(.N(IRQ_W)) u_irq (
    .clk(clk), .rst(rst), .set_vec(events), .clr_wr(clr_wr),
    .clr_vec(clr_bits), .mask(irq_mask), .stat_q(irq_stat), .irq_n_q(irq_n)
  );

  assign dlin_code = state;

  AST_LOSS_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (dlin_code == 2'b10 && $past(dlin_code) == 2'b00) |-> (irq_stat[0] && lcd_defect)); // R8
  AST_LOCK_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (dlin_code == 2'b00 && $past(dlin_code) != 2'b00) |-> (irq_stat[1] && !lcd_defect)); // R5
endmodule

// File: tb/sim_atm_cell_delin.sv
module sim_atm_cell_delin;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_vld = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic [3:0] delta_thr = 4'd2;
  logic [3:0] alpha_thr = 4'd3;
  logic [3:0] irq_mask = 4'h0;
  logic       clr_wr = 1'b0;
  logic [3:0] clr_bits = 4'h0;
  logic       lcd_defect, irq_n, cell_mark;
  logic [1:0] dlin_code;
  logic [3:0] irq_stat;

  int n_tests = 0;
  int n_fail  = 0;
  bit gap     = 1'b0;

  atm_cell_delin u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_byte(in_byte),
    .delta_thr(delta_thr), .alpha_thr(alpha_thr), .irq_mask(irq_mask),
    .clr_wr(clr_wr), .clr_bits(clr_bits), .lcd_defect(lcd_defect),
    .dlin_code(dlin_code), .irq_stat(irq_stat), .irq_n(irq_n),
    .cell_mark(cell_mark)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // err[39:0], code[1:0], stat[3:0], mark  (thresholds 2 / 3)
  localparam logic [46:0] VEC [12] = '{
    {40'h00_0000_0000, 2'b01, 4'h0, 1'b0},
    {40'h00_0000_0000, 2'b01, 4'h0, 1'b0},
    {40'h00_0000_0000, 2'b00, 4'h2, 1'b1},
    {40'h00_0000_2000, 2'b00, 4'hA, 1'b1},
    {40'h00_0000_0001, 2'b00, 4'hE, 1'b0},
    {40'h00_0000_0000, 2'b00, 4'hE, 1'b1},
    {40'h00_8000_0001, 2'b00, 4'hE, 1'b0},
    {40'h03_0000_0000, 2'b00, 4'hE, 1'b0},
    {40'h00_0000_0000, 2'b00, 4'hE, 1'b1},
    {40'h10_0000_0000, 2'b00, 4'hE, 1'b1},
    {40'h00_00C0_0000, 2'b00, 4'hE, 1'b0},
    {40'h00_0000_0081, 2'b10, 4'hF, 1'b0}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Bit-serial reference HEC over 32 header bits, MSB first.
  function automatic logic [7:0] ref_hec(input logic [31:0] h);
    logic [7:0] c = 8'h00;
    logic fb;
    for (int i = 31; i >= 0; i--) begin
      fb = c[7] ^ h[i];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c ^ 8'h55;
  endfunction

  function automatic logic [31:0] hdr_of(input logic [7:0] idx);
    return {idx, idx ^ 8'h5A, 8'h3C, idx + 8'd1};
  endfunction

  task automatic push(input logic [7:0] b);
    if (gap) begin
      in_vld = 1'b0; in_byte = 8'hA5;
      @(negedge clk);
    end
    in_vld = 1'b1; in_byte = b;
    @(negedge clk);
    in_vld = 1'b0; in_byte = 8'hFF;
  endtask

  task automatic send_hdr(input logic [7:0] idx, input logic [39:0] err);
    logic [39:0] f;
    f = {hdr_of(idx), ref_hec(hdr_of(idx))} ^ err;
    for (int k = 4; k >= 0; k--) push(f[k*8 +: 8]);
  endtask

  task automatic send_payload();
    for (int k = 0; k < 48; k++) push(8'h6B ^ 8'(k));
  endtask

  task automatic do_reset();
    rst = 1'b1; in_vld = 1'b0; clr_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]  junk;
    logic [31:0] h;
    do_reset();
    // R1 reset state
    chk("R1", "code", 32'(dlin_code), 32'h2);
    chk("R1", "lcd", 32'(lcd_defect), 32'h1);
    chk("R1", "stat", 32'(irq_stat), 32'h0);
    chk("R1", "irq_n", 32'(irq_n), 32'h1);
    chk("R1", "mark", 32'(cell_mark), 32'h0);

    // Table walk: R3 R5 R6 R7 R9 R8 R13 with thresholds 2/3
    for (int i = 0; i < 12; i++) begin
      send_hdr(8'(i), VEC[i][46:7]);
      chk("R5/R6/R7/R8/R9", $sformatf("row %0d code", i), 32'(dlin_code), 32'(VEC[i][6:5]));
      chk("R5/R8", $sformatf("row %0d lcd", i), 32'(lcd_defect), 32'(VEC[i][6:5] != 2'b00));
      chk("R6/R7/R10", $sformatf("row %0d stat", i), 32'(irq_stat), 32'(VEC[i][4:1]));
      chk("R13", $sformatf("row %0d mark", i), 32'(cell_mark), 32'(VEC[i][0]));
      chk("R11", $sformatf("row %0d irq_n masked", i), 32'(irq_n), 32'h1);
      if (i < 11) send_payload();
    end

    // R10 write-one-to-clear, R11 mask
    clr_wr = 1'b1; clr_bits = 4'b0101;
    @(negedge clk);
    clr_wr = 1'b0;
    chk("R10", "clear 0101", 32'(irq_stat), 32'hA);
    clr_wr = 1'b1; clr_bits = 4'b0000;
    @(negedge clk);
    clr_wr = 1'b0;
    chk("R10", "zero write", 32'(irq_stat), 32'hA);
    irq_mask = 4'b1000;
    @(negedge clk);
    chk("R11", "bit3 enabled", 32'(irq_n), 32'h0);
    clr_wr = 1'b1; clr_bits = 4'b1000;
    @(negedge clk);
    clr_wr = 1'b0;
    chk("R10", "clear bit3", 32'(irq_stat), 32'h2);
    chk("R11", "no enabled bit", 32'(irq_n), 32'h1);
    irq_mask = 4'b0010;
    @(negedge clk);
    chk("R11", "bit1 enabled", 32'(irq_n), 32'h0);
    irq_mask = 4'h0;

    // R2: check byte without the 8'h55 offset is not a header
    do_reset();
    h = hdr_of(8'h40);
    for (int k = 3; k >= 0; k--) push(h[k*8 +: 8]);
    push(ref_hec(h) ^ 8'h55);
    chk("R2", "raw crc rejected", 32'(dlin_code), 32'h2);

    // R3 sliding search with junk prefix, then R4 tentative failure
    do_reset();
    h = hdr_of(8'h20);
    junk = 8'h01;
    for (int v = 1; v < 256; v++) begin
      if (ref_hec({8'(v), 8'(v), 8'(v), h[31:24]}) != h[23:16] &&
          ref_hec({8'(v), 8'(v), h[31:16]}) != h[15:8] &&
          ref_hec({8'(v), h[31:8]}) != h[7:0]) begin
        junk = 8'(v);
        break;
      end
    end
    repeat (3) push(junk);
    for (int k = 3; k >= 0; k--) push(h[k*8 +: 8]);
    chk("R3", "still searching before check byte", 32'(dlin_code), 32'h2);
    push(ref_hec(h));
    chk("R3", "tentative at check byte", 32'(dlin_code), 32'h1);
    send_payload();
    send_hdr(8'h21, 40'h0);
    chk("R3", "53-byte slot accepted", 32'(dlin_code), 32'h1);
    send_payload();
    send_hdr(8'h22, 40'h00_0000_0003);
    chk("R4", "bad header returns to search", 32'(dlin_code), 32'h2);
    chk("R4", "lcd stays set", 32'(lcd_defect), 32'h1);
    chk("R4", "no declaration bit", 32'(irq_stat), 32'h0);

    // R12 + R5 default delta: gapped stream with garbage on idle cycles
    do_reset();
    delta_thr = 4'd0; alpha_thr = 4'd0;
    gap = 1'b1;
    for (int c = 0; c < 7; c++) begin
      send_hdr(8'(8'h60 + c), 40'h0);
      if (c == 5) chk("R12", "gapped cell 6 tentative", 32'(dlin_code), 32'h1);
      if (c == 6) begin
        chk("R5", "default delta locks", 32'(dlin_code), 32'h0);
        chk("R5", "clear bit", 32'(irq_stat), 32'h2);
      end
      send_payload();
    end
    gap = 1'b0;
    // R8 default alpha
    for (int c = 0; c < 7; c++) begin
      send_hdr(8'(8'h70 + c), 40'h00_0000_0003);
      if (c == 5) chk("R8", "six errored stay locked", 32'(dlin_code), 32'h0);
      if (c == 6) begin
        chk("R8", "seventh errored loses lock", 32'(dlin_code), 32'h2);
        chk("R8", "declaration bit", 32'(irq_stat), 32'h7);
        chk("R8", "lcd set", 32'(lcd_defect), 32'h1);
      end
      else send_payload();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule